// File: doc/BRIEF.md
# Synchronous Burst SRAM Write Front-End

This block is the control front end of a synchronous cache SRAM model with a shared data bus. It decodes two address strobes, three chip enables and the write controls. From these it classifies each clock cycle as a write, a read, a deselect or an idle cycle. The two address strobes are one from the memory controller and one from the processor. The write controls are a global write, a byte-write enable and one enable per byte lane. A controller-strobe write completes in a single clock. Each selected lane is stored into the internal array at the address on the address pins in that same cycle. Unselected lanes keep their previous contents.

The data word is 18 bits wide and is split into two lanes. Each lane holds 8 data bits and 1 parity bit. Bit positions in the word: bits [7:0] are the lane 0 data, bits [15:8] are the lane 1 data, bit 16 is the lane 0 parity and bit 17 is the lane 1 parity.

On every selected strobe, the address is captured into an address register. A separate burst-sequencing block uses that register. Reads go through one registered output stage. The block produces a bus-driver enable. That enable is forced low whenever a write cycle is decoded at the inputs, whatever the output-enable pin does.

Top module: `sbsram_front`

## Requirements
- R1: After synchronous reset, `addr_q` is 0 and `drv_en` is 0.
- R2: A write happens on a rising edge only when `ctl_stb_n` is 0, `cpu_stb_n` is 1, `en_a_n` is 0, `en_b` is 1 and `en_c_n` is 0, and at least one lane is selected. If no lane is selected (`gwr_n`=1 and either `bwe_n`=1 or `lane_n`=2'b11), the array is left unchanged.
- R3: With `gwr_n`=0, all 18 bits are written, whatever the values of `bwe_n` and `lane_n`.
- R4: With `gwr_n`=1 and `bwe_n`=0, lane i is written only if `lane_n[i]` is 0. Lane 0 is bits {16,[7:0]} and lane 1 is bits {17,[15:8]}. An unselected lane keeps its old value.
- R5: With `cpu_stb_n` low, no write occurs, even if the write controls request one.
- R6: If any chip enable is inactive during a strobe, there is no array access. `addr_q` holds its value and `drv_en` is 0 in the following cycle.
- R7: A selected strobe loads `addr` into `addr_q` on that edge, for both reads and writes.
- R8: A selected strobe that is not a write is a read. After that edge, `rdata` holds the stored word at `addr`. In the following cycle, `drv_en` is 1 when `oe_n` is 0.
- R9: `drv_en` is 0 in any cycle where `oe_n` is 1, and in any cycle where a write is decoded at the inputs, even with `oe_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 2 | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | 18 | Write data and parity from the bus |
| rdata | output | 18 | Registered read data |
| drv_en | output | 1 | Enable for the bus output drivers |
| addr_q | output | ADDR_W | Captured address for the burst block |

## Verification
Each table vector first fills an address with a known background word, then applies one control pattern, then reads the word back. Partial-lane writes therefore expose any corruption of the unselected lane, including its parity bit. Some designs would let the byte enables mask a global write, swap the lane-to-parity mapping, or accept a write while the processor strobe is low. Others would ignore one of the three chip enables. Each of these mistakes produces a readback that differs from the background or from the merged word. Directed tests apply a write pattern in the cycle after a read with the output enable asserted, where a design that respected only `oe_n` would keep driving the bus. They also apply a deselected strobe with a new address, where a design that loaded the register anyway would show the wrong `addr_q`.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES   = 2;
  localparam int LANE_DW = 8;
  localparam int DQ_W    = LANES * LANE_DW;
  localparam int DATA_W  = DQ_W + LANES;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_DESEL = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e             acc;
    logic [LANES-1:0] lane_we;
  } dec_t;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
(
  input  logic             ctl_stb_n,
  input  logic             cpu_stb_n,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             gwr_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_n,
  output dec_t             dec
);
  logic             sel;
  logic             strobe;
  logic [LANES-1:0] lanes;

  always_comb begin
    sel    = !en_a_n && en_b && !en_c_n;
    strobe = !ctl_stb_n || !cpu_stb_n;
    if (!gwr_n)      lanes = '1;
    else if (!bwe_n) lanes = ~lane_n;
    else             lanes = '0;

    dec.lane_we = '0;
    if (!strobe)
      dec.acc = ACC_IDLE;
    else if (!sel)
      dec.acc = ACC_DESEL;
    else if (!ctl_stb_n && cpu_stb_n && (|lanes)) begin
      dec.acc     = ACC_WRITE;
      dec.lane_we = lanes;
    end else
      dec.acc = ACC_READ;
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LW    = LANE_DW + 1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] din;
    logic [LW-1:0] dout;

    assign din = {wdata[DQ_W+i], wdata[i*LANE_DW +: LANE_DW]};

    always_ff @(posedge clk) begin
      if (we[i]) mem[addr] <= din;
      if (re)    dout      <= mem[addr];
    end

    assign rdata[i*LANE_DW +: LANE_DW] = dout[LANE_DW-1:0];
    assign rdata[DQ_W+i]               = dout[LANE_DW];
  end
endmodule

// File: rtl/sbsram_front.sv
module sbsram_front
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_stb_n,
  input  logic              cpu_stb_n,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              en_c_n,
  input  logic              gwr_n,
  input  logic              bwe_n,
  input  logic [1:0]        lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic [17:0]       wdata,
  output logic [17:0]       rdata,
  output logic              drv_en,
  output logic [ADDR_W-1:0] addr_q
);
  dec_t dec;
  logic rd_valid;
  logic is_rd;
  logic is_wr;

  sbsram_decode u_dec (
    .ctl_stb_n (ctl_stb_n),
    .cpu_stb_n (cpu_stb_n),
    .en_a_n    (en_a_n),
    .en_b      (en_b),
    .en_c_n    (en_c_n),
    .gwr_n     (gwr_n),
    .bwe_n     (bwe_n),
    .lane_n    (lane_n),
    .dec       (dec)
  );

  assign is_rd = (dec.acc == ACC_READ);
  assign is_wr = (dec.acc == ACC_WRITE);

  sbsram_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk   (clk),
    .we    (dec.lane_we),
    .re    (is_rd),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (is_rd || is_wr) addr_q <= addr;
      rd_valid <= is_rd;
    end
  end

  assign drv_en = rd_valid && !oe_n && !is_wr;
endmodule

// File: rtl/sbsram_front_chk.sv
module sbsram_front_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_stb_n,
  input logic              cpu_stb_n,
  input logic              en_a_n,
  input logic              en_b,
  input logic              en_c_n,
  input logic              gwr_n,
  input logic              bwe_n,
  input logic [1:0]        lane_n,
  input logic [ADDR_W-1:0] addr,
  input logic              oe_n,
  input logic              drv_en,
  input logic [ADDR_W-1:0] addr_q
);
  logic sel, stb, any_lane, wr_req;
  assign sel      = !en_a_n && en_b && !en_c_n;
  assign stb      = !ctl_stb_n || !cpu_stb_n;
  assign any_lane = !gwr_n || (!bwe_n && (lane_n != 2'b11));
  assign wr_req   = !ctl_stb_n && cpu_stb_n && sel && any_lane;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (addr_q == '0));

  assert_oe_release_R9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !drv_en);

  assert_write_hiz_R9: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> !drv_en);

  assert_desel_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (stb && !sel) |=> ($stable(addr_q) && !drv_en));

  assert_addr_load_R7: assert property (@(posedge clk) disable iff (rst)
    (stb && sel) |=> (addr_q == $past(addr)));

  assert_read_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (stb && sel && !wr_req) |=> (drv_en || oe_n || wr_req));
endmodule

bind sbsram_front sbsram_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_stb_n (ctl_stb_n),
  .cpu_stb_n (cpu_stb_n),
  .en_a_n    (en_a_n),
  .en_b      (en_b),
  .en_c_n    (en_c_n),
  .gwr_n     (gwr_n),
  .bwe_n     (bwe_n),
  .lane_n    (lane_n),
  .addr      (addr),
  .oe_n      (oe_n),
  .drv_en    (drv_en),
  .addr_q    (addr_q)
);

// File: tb/sbsram_front_test.sv
module sbsram_front_test;
  localparam int AW = 10;
  localparam logic [17:0] BG = 18'h3C3C3;
  localparam logic [17:0] WD = 18'h12345;

  typedef struct packed {
    logic        ctl_n;
    logic        cpu_n;
    logic        ea_n;
    logic        eb;
    logic        ec_n;
    logic        gw_n;
    logic        be_n;
    logic [1:0]  ln_n;
    logic [3:0]  req;
    logic [17:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1,2'b11, 4'd3, 18'h12345}, // R3 global
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,2'b11, 4'd3, 18'h12345}, // R3 global overrides lanes
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,2'b10, 4'd4, 18'h3C345}, // R4 lane 0 only
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,2'b01, 4'd4, 18'h123C3}, // R4 lane 1 only
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,2'b00, 4'd4, 18'h12345}, // R4 both lanes
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,2'b00, 4'd2, 18'h3C3C3}, // R2 no lane selected
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,2'b11, 4'd5, 18'h3C3C3}, // R5 cpu strobe blocks
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,2'b11, 4'd6, 18'h3C3C3}, // R6 en_a off
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,2'b11, 4'd6, 18'h3C3C3}, // R6 en_b off
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,2'b11, 4'd6, 18'h3C3C3}, // R6 en_c off
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1,2'b11, 4'd2, 18'h3C3C3}  // R2 no strobe
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_stb_n = 1'b1, cpu_stb_n = 1'b1;
  logic en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
  logic gwr_n = 1'b1, bwe_n = 1'b1;
  logic [1:0] lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic oe_n = 1'b0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic drv_en;
  logic [AW-1:0] addr_q;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sbsram_front #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .ctl_stb_n(ctl_stb_n), .cpu_stb_n(cpu_stb_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .gwr_n(gwr_n),
    .bwe_n(bwe_n), .lane_n(lane_n), .addr(addr), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .drv_en(drv_en), .addr_q(addr_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c_n, input logic p_n, input logic a_n, input logic b,
                       input logic cc_n, input logic g_n, input logic e_n,
                       input logic [1:0] l_n, input logic [AW-1:0] ad, input logic [17:0] d);
    @(negedge clk);
    ctl_stb_n = c_n; cpu_stb_n = p_n; en_a_n = a_n; en_b = b; en_c_n = cc_n;
    gwr_n = g_n; bwe_n = e_n; lane_n = l_n; addr = ad; wdata = d;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, addr, wdata);
  endtask

  task automatic gwrite(input logic [AW-1:0] ad, input logic [17:0] d);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, ad, d);
  endtask

  task automatic rd(input logic [AW-1:0] ad);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, ad, wdata);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 addr_q", 32'(addr_q), 32'h0);
    check("R1 drv_en", 32'(drv_en), 32'h0);

    // Table walk: background, pattern, readback
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      a = AW'(16 * i + 3);
      gwrite(a, BG);
      drive(VECS[i].ctl_n, VECS[i].cpu_n, VECS[i].ea_n, VECS[i].eb, VECS[i].ec_n,
            VECS[i].gw_n, VECS[i].be_n, VECS[i].ln_n, a, WD);
      rd(a);
      idle();
      #1;
      check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), 32'(rdata), 32'(VECS[i].exp));
      check($sformatf("R8 vec%0d drv_en", i), 32'(drv_en), 32'h1);
    end

    // R9: write decoded while a read would drive, with oe_n low
    rd(AW'(10'h003));
    gwrite(AW'(10'h3F0), 18'h00001);
    #1;
    check("R9 drv_en during write", 32'(drv_en), 32'h0);

    // R9 and R8: output enable gating in the cycle after a read
    rd(AW'(10'h003));
    @(negedge clk);
    ctl_stb_n = 1'b1; cpu_stb_n = 1'b1; oe_n = 1'b1;
    #1;
    check("R9 drv_en oe_n high", 32'(drv_en), 32'h0);
    oe_n = 1'b0;
    #1;
    check("R8 drv_en oe_n low", 32'(drv_en), 32'h1);

    // R7: read loads the address register
    rd(AW'(10'h155));
    idle();
    #1;
    check("R7 addr_q after read", 32'(addr_q), 32'h155);

    // R6: deselected strobe leaves address and drivers alone
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, AW'(10'h2AA), 18'h0);
    idle();
    #1;
    check("R6 addr_q held", 32'(addr_q), 32'h155);
    check("R6 drv_en off", 32'(drv_en), 32'h0);

    // R7: write loads the address register
    gwrite(AW'(10'h0F0), 18'h2BEEF);
    idle();
    #1;
    check("R7 addr_q after write", 32'(addr_q), 32'h0F0);
    check("R9 drv_en after write", 32'(drv_en), 32'h0);

    // R2 and R8: a controller strobe with no lane selected acts as a read
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, AW'(10'h0F0), 18'h0);
    idle();
    #1;
    check("R2 no-lane strobe reads", 32'(rdata), 32'h2BEEF);
    check("R8 drv_en no-lane read", 32'(drv_en), 32'h1);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule